// File: doc/BRIEF.md
# Double-Conversion Weight Calibrator

This block learns the digital weight of each unit capacitor in a charge-redistribution converter while the converter keeps running. Every input sample is converted twice. In the second conversion, the unit under test trades places with the reference unit (unit 0), and the reference unit then serves as termination. The block takes both results and the polarity that the unit under test was switched to in the first conversion. It forms the difference of the two results and nudges that unit's weight by a shifted fraction of the difference. The sign of the nudge follows the polarity. The block then steps on to the next unit.

The sample value handed downstream is the mean of the two results. Weights are held with extra fractional bits below the nominal code LSB, so that very small corrections accumulate. A read port exposes any stored weight to the logic that rebuilds output codes. Driving the analog swap is left to the converter sequencer, which follows the unit index this block publishes.

Top module: `dcal_top`

## Requirements
- R1: One cycle after a cycle with `smp_vld` high, `avg_vld` is high and `avg_out` equals floor((`conv_first` + `conv_second`) / 2). One cycle after a cycle with `smp_vld` low, `avg_vld` is low.
- R2: The correction step is d = `conv_first` − `conv_second`, scaled by 2^FRAC_W and divided by 2^MU_SH, with the quotient truncated toward zero.
- R3: When `unit_dir` = 1 (switched toward the positive reference), the weight of unit `cal_unit` is reduced by the step. The new value can be read on `rd_weight` one cycle after the sample.
- R4: When `unit_dir` = 0 (switched toward ground), the weight of unit `cal_unit` is increased by the step, visible one cycle after the sample.
- R5: `cal_unit` is always in 1..NUM_UNITS. It advances by one per accepted sample and wraps from NUM_UNITS back to 1.
- R6: The weight of unit 0 never changes from its nominal value.
- R7: After reset, every weight equals NOM_UNIT·2^FRAC_W, `cal_unit` = 1 and `avg_vld` = 0.
- R8: A sample with `unit_was_term` = 1 still produces the average, but leaves every weight and `cal_unit` unchanged.
- R9: A weight update saturates at the signed limits of a WEIGHT_W-bit value, −2^(WEIGHT_W−1) and 2^(WEIGHT_W−1)−1.
- R10: With `smp_vld` low, no weight and no `cal_unit` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | Both conversion results of one sample are present |
| conv_first | input | RES_W | Signed result with the unit under test in place |
| conv_second | input | RES_W | Signed result with the unit under test swapped with unit 0 |
| unit_dir | input | 1 | First-conversion polarity of the unit under test: 1 reference, 0 ground |
| unit_was_term | input | 1 | Unit under test acted as termination in the first conversion |
| rd_sel | input | IDX_W | Unit whose weight is shown on `rd_weight` |
| cal_unit | output | IDX_W | Unit currently under calibration |
| avg_vld | output | 1 | `avg_out` holds a new sample value |
| avg_out | output | RES_W | Mean of the two results |
| rd_weight | output | WEIGHT_W | Stored weight of unit `rd_sel` |

## Verification
Two events can land on the same edge: the update of the last unit and the wrap of the index back to unit 1. A weight update can also coincide with the weight pinning at a saturation limit. The stimulus runs long random streams, so the last unit is hit over and over, and a burst of full-scale differences drives every weight into both limits. A bench model that tracks the index and clamps on its own judges each weight after the edge, along with the next index.

// File: rtl/dcal_pkg.sv
package dcal_pkg;

    typedef enum logic {
        SW_GROUND = 1'b0,
        SW_REFPOS = 1'b1
    } sw_dir_e;

endpackage

// File: rtl/dcal_step.sv
module dcal_step #(
    parameter int RES_W  = 14,
    parameter int FRAC_W = 8,
    parameter int MU_SH  = 12,
    parameter int STEP_W = RES_W + 1 + FRAC_W
) (
    input  logic signed [RES_W-1:0]  first_i,
    input  logic signed [RES_W-1:0]  second_i,
    output logic signed [STEP_W-1:0] step_o
);
    localparam int DIFF_W = RES_W + 1;

    logic signed [DIFF_W-1:0] diff;
    logic signed [STEP_W:0]   scaled;
    logic signed [STEP_W:0]   bias_v;
    logic signed [STEP_W:0]   biased;
    logic signed [STEP_W:0]   shifted;

    always_comb begin
        diff    = {first_i[RES_W-1], first_i} - {second_i[RES_W-1], second_i};
        scaled  = {diff[DIFF_W-1], diff, {FRAC_W{1'b0}}};
        // a negative value gets 2^MU-1 added so the shift truncates toward zero
        bias_v  = scaled[STEP_W] ? {{(STEP_W+1-MU_SH){1'b0}}, {MU_SH{1'b1}}} : '0;
        biased  = scaled + bias_v;
        shifted = biased >>> MU_SH;
        step_o  = shifted[STEP_W-1:0];
    end

    // R2: the step never points opposite to the difference
    always_comb begin
        assert_step_sign_R2: assert (!((diff > 0) && (step_o < 0)) && !((diff < 0) && (step_o > 0)));
    end

endmodule

// File: rtl/dcal_sat_acc.sv
module dcal_sat_acc #(
    parameter int WEIGHT_W = 26,
    parameter int STEP_W   = 23
) (
    input  logic signed [WEIGHT_W-1:0] w_i,
    input  logic signed [STEP_W-1:0]   step_i,
    input  logic                       sub_i,
    output logic signed [WEIGHT_W-1:0] w_o
);
    localparam int EXT_W = ((WEIGHT_W > STEP_W) ? WEIGHT_W : STEP_W) + 2;
    localparam logic signed [EXT_W-1:0] MAX_V =
        {{(EXT_W-WEIGHT_W+1){1'b0}}, {(WEIGHT_W-1){1'b1}}};
    localparam logic signed [EXT_W-1:0] MIN_V =
        {{(EXT_W-WEIGHT_W+1){1'b1}}, {(WEIGHT_W-1){1'b0}}};

    logic signed [EXT_W-1:0] a_ext;
    logic signed [EXT_W-1:0] b_ext;
    logic signed [EXT_W-1:0] sum;
    logic signed [EXT_W-1:0] clamped;

    always_comb begin
        a_ext = EXT_W'(w_i);
        b_ext = EXT_W'(step_i);
        sum   = sub_i ? (a_ext - b_ext) : (a_ext + b_ext);
        if (sum > MAX_V) begin
            clamped = MAX_V;
        end else if (sum < MIN_V) begin
            clamped = MIN_V;
        end else begin
            clamped = sum;
        end
        w_o = clamped[WEIGHT_W-1:0];
    end

endmodule

// File: rtl/dcal_avg.sv
module dcal_avg #(
    parameter int RES_W = 14
) (
    input  logic signed [RES_W-1:0] first_i,
    input  logic signed [RES_W-1:0] second_i,
    output logic signed [RES_W-1:0] avg_o
);
    logic signed [RES_W:0] total;
    logic signed [RES_W:0] half;

    always_comb begin
        total = {first_i[RES_W-1], first_i} + {second_i[RES_W-1], second_i};
        half  = total >>> 1;
        avg_o = half[RES_W-1:0];
    end

endmodule

// File: rtl/dcal_top.sv
module dcal_top #(
    parameter int NUM_UNITS = 15,
    parameter int RES_W     = 14,
    parameter int WEIGHT_W  = 26,
    parameter int FRAC_W    = 8,
    parameter int MU_SH     = 12,
    parameter int NOM_UNIT  = 2,
    parameter int IDX_W     = $clog2(NUM_UNITS + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       smp_vld,
    input  logic signed [RES_W-1:0]    conv_first,
    input  logic signed [RES_W-1:0]    conv_second,
    input  logic                       unit_dir,
    input  logic                       unit_was_term,
    input  logic [IDX_W-1:0]           rd_sel,
    output logic [IDX_W-1:0]           cal_unit,
    output logic                       avg_vld,
    output logic signed [RES_W-1:0]    avg_out,
    output logic signed [WEIGHT_W-1:0] rd_weight
);
    import dcal_pkg::*;

    localparam int STEP_W = RES_W + 1 + FRAC_W;
    localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(NUM_UNITS);
    localparam logic [IDX_W-1:0] FIRST_IDX = IDX_W'(1);
    localparam logic signed [WEIGHT_W-1:0] NOM_W = WEIGHT_W'(NOM_UNIT) <<< FRAC_W;

    typedef struct packed {
        logic [IDX_W-1:0]                     idx;
        logic                                 ovld;
        logic [RES_W-1:0]                     avg;
        logic [NUM_UNITS:0][WEIGHT_W-1:0]     w;
    } cal_state_t;

    cal_state_t st_d, st_q;

    logic signed [STEP_W-1:0]   step_val;
    logic signed [RES_W-1:0]    avg_val;
    logic signed [WEIGHT_W-1:0] cur_w;
    logic signed [WEIGHT_W-1:0] new_w;
    sw_dir_e                    dir_e;

    assign dir_e = sw_dir_e'(unit_dir);
    assign cur_w = st_q.w[st_q.idx];

    dcal_step #(
        .RES_W (RES_W),
        .FRAC_W(FRAC_W),
        .MU_SH (MU_SH),
        .STEP_W(STEP_W)
    ) step_i (
        .first_i (conv_first),
        .second_i(conv_second),
        .step_o  (step_val)
    );

    dcal_avg #(
        .RES_W(RES_W)
    ) avg_i (
        .first_i (conv_first),
        .second_i(conv_second),
        .avg_o   (avg_val)
    );

    dcal_sat_acc #(
        .WEIGHT_W(WEIGHT_W),
        .STEP_W  (STEP_W)
    ) acc_i (
        .w_i   (cur_w),
        .step_i(step_val),
        .sub_i (dir_e == SW_REFPOS),
        .w_o   (new_w)
    );

    always_comb begin
        st_d      = st_q;
        st_d.ovld = smp_vld;
        if (smp_vld) begin
            st_d.avg = avg_val;
            if (!unit_was_term) begin
                st_d.w[st_q.idx] = new_w;
                st_d.idx = (st_q.idx == LAST_IDX) ? FIRST_IDX : st_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.idx  <= FIRST_IDX;
            st_q.ovld <= 1'b0;
            st_q.avg  <= '0;
            for (int k = 0; k <= NUM_UNITS; k++) begin
                st_q.w[k] <= NOM_W;
            end
        end else begin
            st_q <= st_d;
        end
    end

    assign cal_unit  = st_q.idx;
    assign avg_vld   = st_q.ovld;
    assign avg_out   = st_q.avg;
    assign rd_weight = (int'(rd_sel) <= NUM_UNITS) ? st_q.w[rd_sel] : '0;

    assert_ref_fixed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $signed(st_q.w[0]) == NOM_W);

    assert_idx_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_unit >= FIRST_IDX) && (cal_unit <= LAST_IDX));

    assert_idx_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && !unit_was_term && cal_unit == LAST_IDX) |=> (cal_unit == FIRST_IDX));

    assert_idx_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && !unit_was_term && cal_unit != LAST_IDX) |=> (cal_unit == $past(cal_unit) + 1'b1));

    assert_term_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && unit_was_term) |=> ($stable(cal_unit) && $stable(st_q.w) && avg_vld));

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_vld |=> ($stable(cal_unit) && $stable(st_q.w) && !avg_vld));

    assert_out_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
        smp_vld |=> avg_vld);

endmodule

// File: tb/dcal_top_tb_top.sv
module dcal_top_tb_top;

    localparam int M      = 7;
    localparam int RW     = 14;
    localparam int WW     = 16;
    localparam int FW     = 8;
    localparam int MU     = 12;
    localparam int NOMU   = 2;
    localparam int IW     = 3;
    localparam longint WMAX = (64'sd1 <<< (WW - 1)) - 1;
    localparam longint WMIN = -(64'sd1 <<< (WW - 1));
    localparam longint NOMV = longint'(NOMU) <<< FW;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 smp_vld = 1'b0;
    logic signed [RW-1:0] conv_first = '0;
    logic signed [RW-1:0] conv_second = '0;
    logic                 unit_dir = 1'b0;
    logic                 unit_was_term = 1'b0;
    logic [IW-1:0]        rd_sel = '0;
    logic [IW-1:0]        cal_unit;
    logic                 avg_vld;
    logic signed [RW-1:0] avg_out;
    logic signed [WW-1:0] rd_weight;

    int     n_checks = 0;
    int     n_errors = 0;
    int     cycles   = 0;
    bit     done     = 1'b0;
    longint mw [0:M];
    int     midx;

    always #4 clk = ~clk;

    dcal_top #(
        .NUM_UNITS(M), .RES_W(RW), .WEIGHT_W(WW),
        .FRAC_W(FW), .MU_SH(MU), .NOM_UNIT(NOMU), .IDX_W(IW)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld),
        .conv_first(conv_first), .conv_second(conv_second),
        .unit_dir(unit_dir), .unit_was_term(unit_was_term),
        .rd_sel(rd_sel), .cal_unit(cal_unit), .avg_vld(avg_vld),
        .avg_out(avg_out), .rd_weight(rd_weight)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic longint exp_step(input longint a, input longint b);
        longint p;
        p = (a - b) * (64'sd1 <<< FW);
        return p / (64'sd1 <<< MU);
    endfunction

    function automatic longint exp_avg(input longint a, input longint b);
        longint s;
        s = a + b;
        return (s >= 0) ? s / 2 : -((1 - s) / 2);
    endfunction

    function automatic longint clampw(input longint v);
        if (v > WMAX) return WMAX;
        if (v < WMIN) return WMIN;
        return v;
    endfunction

    task automatic read_w(input int u, output longint v);
        rd_sel = IW'(u);
        #1;
        v = longint'(rd_weight);
    endtask

    // called at a falling edge; returns at the next falling edge after checks
    task automatic sample(input int a, input int b, input bit dir, input bit term, input string tag);
        longint st, ew, got;
        int     used, nidx;
        conv_first    = RW'(a);
        conv_second   = RW'(b);
        unit_dir      = dir;
        unit_was_term = term;
        smp_vld       = 1'b1;
        used = midx;
        nidx = midx;
        st   = exp_step(a, b);
        if (!term) begin
            mw[used] = clampw(dir ? mw[used] - st : mw[used] + st);
            nidx = (midx == M) ? 1 : midx + 1;
        end
        ew = mw[used];
        @(posedge clk);
        @(negedge clk);
        smp_vld = 1'b0;
        check(avg_vld == 1'b1, "R1 avg_vld", longint'(avg_vld), 1);
        check(longint'(avg_out) == exp_avg(a, b), "R1 avg_out", longint'(avg_out), exp_avg(a, b));
        check(int'(cal_unit) == nidx, (midx == M) ? "R5 wrap" : "R5 index", longint'(cal_unit), nidx);
        read_w(used, got);
        check(got == ew, tag, got, ew);
        read_w(0, got);
        check(got == NOMV, "R6 reference weight", got, NOMV);
        midx = nidx;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        longint v;
        int     seed_sink;
        seed_sink = $urandom(32'd2024);
        for (int k = 0; k <= M; k++) mw[k] = NOMV;
        midx = 1;
        repeat (3) @(negedge clk);
        // R7: reset state
        check(avg_vld == 1'b0, "R7 avg_vld", longint'(avg_vld), 0);
        check(int'(cal_unit) == 1, "R7 cal_unit", longint'(cal_unit), 1);
        for (int k = 0; k <= M; k++) begin
            read_w(k, v);
            check(v == NOMV, "R7 weight", v, NOMV);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R2 rounding toward zero, R4 add direction
        sample(15, 0, 1'b0, 1'b0, "R2 trunc +15");
        sample(0, 15, 1'b0, 1'b0, "R2 trunc -15");
        sample(16, 0, 1'b0, 1'b0, "R2 step +16");
        sample(0, 17, 1'b0, 1'b0, "R2 step -17");
        // R3 subtract direction
        sample(320, 0, 1'b1, 1'b0, "R3 subtract");
        sample(-5, -2, 1'b0, 1'b0, "R4 add");
        // R8 termination skip
        begin
            int hold_idx;
            hold_idx = midx;
            sample(900, -900, 1'b1, 1'b1, "R8 term weight");
            check(int'(cal_unit) == hold_idx, "R8 index held", longint'(cal_unit), hold_idx);
        end
        // R10 idle cycles
        begin
            int hold_idx;
            hold_idx = int'(cal_unit);
            conv_first = 14'sd3000;
            conv_second = -14'sd3000;
            repeat (4) @(negedge clk);
            check(avg_vld == 1'b0, "R10 avg_vld", longint'(avg_vld), 0);
            check(int'(cal_unit) == hold_idx, "R10 index", longint'(cal_unit), hold_idx);
            for (int k = 0; k <= M; k++) begin
                read_w(k, v);
                check(v == mw[k], "R10 weight", v, mw[k]);
            end
        end
        // random stream
        for (int n = 0; n < 400; n++) begin
            int a, b, off;
            bit d, t;
            a   = int'($urandom_range(16383)) - 8192;
            off = int'($urandom_range(400)) - 200;
            b   = a + off;
            if (b > 8191) b = 8191;
            if (b < -8192) b = -8192;
            if ((n % 5) == 0) b = int'($urandom_range(16383)) - 8192;
            d = 1'(($urandom() >> 3) & 1);
            t = (($urandom() % 16) == 0);
            sample(a, b, d, t, d ? "R3 random" : "R4 random");
        end
        // R9 upper saturation
        for (int n = 0; n < 300; n++) sample(8191, -8192, 1'b0, 1'b0, "R9 climb");
        for (int k = 1; k <= M; k++) begin
            read_w(k, v);
            check(v == WMAX, "R9 upper limit", v, WMAX);
        end
        // R9 lower saturation
        for (int n = 0; n < 600; n++) sample(8191, -8192, 1'b1, 1'b0, "R9 fall");
        for (int k = 1; k <= M; k++) begin
            read_w(k, v);
            check(v == WMIN, "R9 lower limit", v, WMIN);
        end
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule